// File: doc/BRIEF.md
# Partitioned Saturating Packed Adder

This block adds or subtracts two 64-bit packed operands as a set of independent integer lanes. A two-bit lane-size input splits the datapath into eight byte lanes, four halfword lanes or two word lanes. The split is made by cutting the carry chain at lane edges, so each lane behaves as its own adder.

Each lane either wraps modulo its width or clamps to its own limits when the result leaves the representable range. The signedness input picks the limits. Signed lanes clamp to the most positive or most negative value. Unsigned lanes clamp to all ones on add and to zero on subtract. A per-byte flag vector reports which lanes were clamped.

The result and the flags are registered. They appear one clock after the inputs are sampled, and a synchronous active-high reset clears them. A packed media or signal-processing datapath uses the block for clipped arithmetic on narrow samples.

Top module: `simd_sat_adder`

## Requirements
- R1: Lane size code 0 gives eight 8-bit lanes, code 1 gives four 16-bit lanes and code 2 gives two 32-bit lanes. Lane k of width w occupies bits [k*w+w-1 : k*w]. No carry or borrow passes from one lane into the next.
- R2: With saturation off (sat_i=0), each lane result is (a+b) mod 2^w or (a-b) mod 2^w, and every flag bit is 0.
- R3: sub_i=1 makes every lane compute a minus b, as a plus the inverted b plus one in each lane.
- R4: With saturation on and signed_i=1, a lane that overflows upward gives its maximum (0x7F, 0x7FFF or 0x7FFFFFFF). A lane that overflows downward gives its minimum (0x80, 0x8000 or 0x80000000).
- R5: With saturation on and signed_i=0, an add whose unsigned sum exceeds the lane range gives all ones.
- R6: With saturation on and signed_i=0, a subtract whose unsigned difference is below zero gives zero.
- R7: Flag bit i (byte i) is 1 exactly when the lane containing byte i was clamped, so all flag bits of one lane are equal. A lane that is in range with saturation on leaves its result and flags unchanged from the wrapped value and zero.
- R8: Lane size code 3 behaves exactly as code 0.
- R9: Result and flags update at the rising clock edge after the inputs are applied. A synchronous reset (rst=1) clears both to zero.
- R10: With saturation off, signed_i has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Lane size: 0 byte, 1 halfword, 2 word, 3 byte |
| sub_i | input | 1 | 1 selects subtract, 0 selects add |
| signed_i | input | 1 | 1 selects signed clamp limits |
| sat_i | input | 1 | 1 enables saturation, 0 gives wrapping |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| res_o | output | 64 | Registered packed result |
| sat_flag_o | output | 8 | Registered per-byte clamp flags |

## Verification
The same operand pattern is run with byte, halfword and word lane sizes. A carry that sits at a byte or halfword edge then yields a different result in each size, which shows whether the chain is cut at the right place. Mixed vectors put lanes that overflow upward, overflow downward and stay in range side by side. These vectors are run signed and unsigned, add and subtract, with saturation on and off, which separates the four clamp values and shows that neighbouring lanes do not disturb each other. Reserved code 3 is compared against byte mode, and a reset applied while operands are active confirms that the registers clear.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    LANE_8   = 2'd0,
    LANE_16  = 2'd1,
    LANE_32  = 2'd2,
    LANE_RSV = 2'd3
  } lane_mode_e;

  // Number of byte slices grouped into one lane; reserved code acts as bytes.
  function automatic int unsigned slices_per_lane(lane_mode_e m);
    case (m)
      LANE_16: return 2;
      LANE_32: return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map
  import simd_pkg::*;
#(
  parameter int NSLICE = 8,
  localparam int IDXW = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  lane_mode_e                   mode,
  output logic [NSLICE-1:0]            first_o,
  output logic [NSLICE-1:0]            last_o,
  output logic [NSLICE-1:0][IDXW-1:0]  top_o
);

  always_comb begin
    int unsigned span;
    span = slices_per_lane(mode);
    for (int i = 0; i < NSLICE; i++) begin
      first_o[i] = ((i % span) == 0);
      last_o[i]  = ((i % span) == (span - 1));
      top_o[i]   = IDXW'((i / span) * span + span - 1);
    end
  end

endmodule

// File: rtl/simd_carry_chain.sv
module simd_carry_chain #(
  parameter int SW     = 8,
  parameter int NSLICE = 8,
  localparam int DW = SW * NSLICE
) (
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  input  logic              sub,
  input  logic [NSLICE-1:0] first,
  output logic [DW-1:0]     sum,
  output logic [NSLICE-1:0] c_msb,
  output logic [NSLICE-1:0] c_out
);

  // One ripple pass; the running carry is reloaded at each lane start.
  always_comb begin
    logic          carry;
    logic [SW-1:0] av;
    logic [SW-1:0] bx;
    logic [SW:0]   full;
    carry = 1'b0;
    for (int i = 0; i < NSLICE; i++) begin
      av = a[i*SW +: SW];
      bx = b[i*SW +: SW] ^ {SW{sub}};
      if (first[i]) carry = sub;
      full = {1'b0, av} + {1'b0, bx} + {{SW{1'b0}}, carry};
      sum[i*SW +: SW] = full[SW-1:0];
      c_out[i] = full[SW];
      c_msb[i] = av[SW-1] ^ bx[SW-1] ^ full[SW-1];
      carry = full[SW];
    end
  end

endmodule

// File: rtl/simd_clamp.sv
module simd_clamp #(
  parameter int SW     = 8,
  parameter int NSLICE = 8,
  localparam int DW   = SW * NSLICE,
  localparam int IDXW = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic [DW-1:0]                sum,
  input  logic [NSLICE-1:0]            c_msb,
  input  logic [NSLICE-1:0]            c_out,
  input  logic [NSLICE-1:0]            last,
  input  logic [NSLICE-1:0][IDXW-1:0]  top,
  input  logic                         sub,
  input  logic                         sgn,
  input  logic                         sat_en,
  output logic [DW-1:0]                res,
  output logic [NSLICE-1:0]            flag
);

  logic [NSLICE-1:0] lane_ovf;
  logic [NSLICE-1:0] hi_dir;

  // Overflow and clamp direction, valid at the top slice of each lane.
  always_comb begin
    for (int i = 0; i < NSLICE; i++) begin
      lane_ovf[i] = sat_en & (sgn ? (c_msb[i] ^ c_out[i])
                                  : (sub ? ~c_out[i] : c_out[i]));
      hi_dir[i]   = sgn ? sum[i*SW + SW - 1] : ~sub;
    end
  end

  // Every slice looks up its lane's verdict and picks its clamp byte.
  always_comb begin
    logic          hit;
    logic          up;
    logic [SW-1:0] lim;
    for (int i = 0; i < NSLICE; i++) begin
      hit = lane_ovf[top[i]];
      up  = hi_dir[top[i]];
      if (sgn)
        lim = up ? (last[i] ? {1'b0, {(SW-1){1'b1}}} : {SW{1'b1}})
                 : (last[i] ? {1'b1, {(SW-1){1'b0}}} : {SW{1'b0}});
      else
        lim = up ? {SW{1'b1}} : {SW{1'b0}};
      res[i*SW +: SW] = hit ? lim : sum[i*SW +: SW];
      flag[i]         = hit;
    end
  end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 8,
  localparam int NSLICE = DATA_W / SLICE_W,
  localparam int IDXW   = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic              sub_i,
  input  logic              signed_i,
  input  logic              sat_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NSLICE-1:0] sat_flag_o
);

  lane_mode_e                  mode_e;
  logic [NSLICE-1:0]           first_w;
  logic [NSLICE-1:0]           last_w;
  logic [NSLICE-1:0][IDXW-1:0] top_w;
  logic [DATA_W-1:0]           sum_w;
  logic [NSLICE-1:0]           cmsb_w;
  logic [NSLICE-1:0]           cout_w;
  logic [DATA_W-1:0]           res_w;
  logic [NSLICE-1:0]           flag_w;

  assign mode_e = lane_mode_e'(mode_i);

  simd_lane_map #(.NSLICE(NSLICE)) u_map (
    .mode(mode_e), .first_o(first_w), .last_o(last_w), .top_o(top_w)
  );

  simd_carry_chain #(.SW(SLICE_W), .NSLICE(NSLICE)) u_chain (
    .a(a_i), .b(b_i), .sub(sub_i), .first(first_w),
    .sum(sum_w), .c_msb(cmsb_w), .c_out(cout_w)
  );

  simd_clamp #(.SW(SLICE_W), .NSLICE(NSLICE)) u_clamp (
    .sum(sum_w), .c_msb(cmsb_w), .c_out(cout_w), .last(last_w), .top(top_w),
    .sub(sub_i), .sgn(signed_i), .sat_en(sat_i), .res(res_w), .flag(flag_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o      <= '0;
      sat_flag_o <= '0;
    end else begin
      res_o      <= res_w;
      sat_flag_o <= flag_w;
    end
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_o == '0 && sat_flag_o == '0));

  // R2
  wrap_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    !sat_i |=> (sat_flag_o == '0));

  // R7
  half_flag_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1) |=> (sat_flag_o[0] == sat_flag_o[1]));

  // R7
  word_flag_group_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd2) |=> ($countones(sat_flag_o[3:0]) == 0 ||
                          $countones(sat_flag_o[3:0]) == 4));

  // R6
  usub_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_i && !signed_i && sub_i) |=>
      (!sat_flag_o[0] || res_o[SLICE_W-1:0] == '0));

  // R5
  uadd_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_i && !signed_i && !sub_i) |=>
      (!sat_flag_o[0] || res_o[SLICE_W-1:0] == '1));

  // R4
  signed_top_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_i && signed_i && mode_i == 2'd0) |=>
      (!sat_flag_o[NSLICE-1] ||
       res_o[DATA_W-1 -: SLICE_W] == {1'b0, {(SLICE_W-1){1'b1}}} ||
       res_o[DATA_W-1 -: SLICE_W] == {1'b1, {(SLICE_W-1){1'b0}}}));

endmodule

// File: tb/simd_sat_adder_bench.sv
module simd_sat_adder_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic        sub;
    logic        sgn;
    logic        sat;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic [7:0]  flg;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    // R1 R2 byte lanes: carry out of each low byte is dropped
    '{2'd0,1'b0,1'b0,1'b0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 64'h0000_0000_0000_0000, 8'h00, 8'd1},
    // R1 halfword lanes: carry reaches the high byte
    '{2'd1,1'b0,1'b0,1'b0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 64'h0100_0100_0100_0100, 8'h00, 8'd1},
    // R1 word lanes: carry crosses the halfword edge
    '{2'd2,1'b0,1'b0,1'b0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 64'h0001_0000_0001_0000, 8'h00, 8'd1},
    // R1 word lanes: carry stops at bit 32
    '{2'd2,1'b0,1'b0,1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 64'h0000_0000_0000_0000, 8'h00, 8'd1},
    // R8 reserved code acts as bytes
    '{2'd3,1'b0,1'b0,1'b0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 64'h0000_0000_0000_0000, 8'h00, 8'd8},
    // R3 byte subtract wraps
    '{2'd0,1'b1,1'b0,1'b0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 8'd3},
    // R3 halfword subtract wraps
    '{2'd1,1'b1,1'b0,1'b0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 64'hFEFF_FEFF_FEFF_FEFF, 8'h00, 8'd3},
    // R4 signed byte add clamps up and down
    '{2'd0,1'b0,1'b1,1'b1, 64'h7F80_7F80_10F0_0000, 64'h01FF_7F80_10F0_0000, 64'h7F80_7F80_20E0_0000, 8'hF0, 8'd4},
    // R5 unsigned byte add clamps to all ones
    '{2'd0,1'b0,1'b0,1'b1, 64'h7F80_7F80_10F0_0000, 64'h01FF_7F80_10F0_0000, 64'h80FF_FEFF_20FF_0000, 8'h54, 8'd5},
    // R6 unsigned byte subtract clamps to zero
    '{2'd0,1'b1,1'b0,1'b1, 64'h0510_FF00_0000_0000, 64'h0610_0001_0000_0000, 64'h0000_FF00_0000_0000, 8'h90, 8'd6},
    // R4 signed halfword subtract
    '{2'd1,1'b1,1'b1,1'b1, 64'h8000_7FFF_0005_FFFF, 64'h0001_FFFF_0007_0001, 64'h8000_7FFF_FFFE_FFFE, 8'hF0, 8'd4},
    // R4 signed word add
    '{2'd2,1'b0,1'b1,1'b1, 64'h7FFF_FFF0_8000_0010, 64'h0000_0100_FFFF_FFE0, 64'h7FFF_FFFF_8000_0000, 8'hFF, 8'd4},
    // R5 unsigned word add, one lane in range
    '{2'd2,1'b0,1'b0,1'b1, 64'hFFFF_0000_0000_0001, 64'h0001_0000_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 8'hF0, 8'd5},
    // R10 signedness ignored when wrapping
    '{2'd0,1'b0,1'b1,1'b0, 64'h7F80_7F80_10F0_0000, 64'h01FF_7F80_10F0_0000, 64'h807F_FE00_20E0_0000, 8'h00, 8'd10},
    // R8 reserved code with signed clamp
    '{2'd3,1'b0,1'b1,1'b1, 64'h7F80_7F80_10F0_0000, 64'h01FF_7F80_10F0_0000, 64'h7F80_7F80_20E0_0000, 8'hF0, 8'd8},
    // R6 unsigned halfword subtract clamps to zero
    '{2'd1,1'b1,1'b0,1'b1, 64'h0100_0000_0000_0000, 64'h0101_0000_0000_0000, 64'h0000_0000_0000_0000, 8'hC0, 8'd6},
    // R7 saturation on, nothing overflows
    '{2'd0,1'b0,1'b0,1'b1, 64'h0102_0304_0506_0708, 64'h0101_0101_0101_0101, 64'h0203_0405_0607_0809, 8'h00, 8'd7}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_i = '0;
  logic        sub_i = 1'b0;
  logic        signed_i = 1'b0;
  logic        sat_i = 1'b0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] res_o;
  logic [7:0]  sat_flag_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_sat_adder u_simd_sat_adder (
    .clk(clk), .rst(rst), .mode_i(mode_i), .sub_i(sub_i), .signed_i(signed_i),
    .sat_i(sat_i), .a_i(a_i), .b_i(b_i), .res_o(res_o), .sat_flag_o(sat_flag_o)
  );

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(vec_t v);
    mode_i = v.mode; sub_i = v.sub; signed_i = v.sgn; sat_i = v.sat;
    a_i = v.a; b_i = v.b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset res", res_o, 64'h0);
    check("R9 reset flags", {56'h0, sat_flag_o}, 64'h0);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      drive(VECS[k]);
      @(negedge clk);
      check($sformatf("R%0d vec %0d res", VECS[k].req, k), res_o, VECS[k].res);
      // R7 flag vector per vector
      check($sformatf("R7 vec %0d flags", k), {56'h0, sat_flag_o}, {56'h0, VECS[k].flg});
    end

    // R9 outputs hold until the next edge, then reset clears them
    drive(VECS[7]);
    @(negedge clk);
    check("R9 registered result", res_o, 64'h7F80_7F80_20E0_0000);
    rst = 1'b1;
    @(negedge clk);
    check("R9 sync reset res", res_o, 64'h0);
    check("R9 sync reset flags", {56'h0, sat_flag_o}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 after release", res_o, 64'h7F80_7F80_20E0_0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule